// File: doc/BRIEF.md
# Vertical Luma Decimation Filter

This block shrinks a picture vertically by folding groups of consecutive luma lines into a single output line. In the three-line mode every third line is kept; in the four-line mode every fourth line is kept. Each kept output sample is a weighted average of the samples in the same column across the lines of its group. A per-column line buffer holds the partial sums while the group is being received. Samples taken on lines that are not the last of their group produce no output. The filtered stream then passes through a fixed-length delay so that the luma stays aligned with a slower colour-difference path.

The input is a 6-bit luma stream with valid/ready handshaking. A line-start flag marks the first sample of each line, and a field-start flag, given together with the first line-start of a field, restarts the line group. The output is a 6-bit valid/ready stream. Back-pressure passes straight through: `in_ready` equals `out_ready`. The whole delay pipeline, including empty slots, advances only on cycles where `out_ready` is high. An offered output holds its value until it is taken, so no sample is lost or duplicated.

Top module: `luma_vdecim`

## Requirements
- R1: While `rst_n` is low and after reset, `out_valid` is 0. `in_ready` always equals `out_ready`.
- R2: With `mode_sel`=0 (three-line mode), lines within a field are numbered 0,1,2,0,1,2,… For samples a, b, c at the same column of lines 0, 1 and 2, the output sample emitted on line 2 is (a + 2b + c + 2) >> 2.
- R3: With `mode_sel`=1 (four-line mode), lines are numbered 0..3 cyclically. The sample emitted on line 3 is (a + b + c + d + 2) >> 2.
- R4: A sample accepted on a line that is not the last of its group never produces an output. Per field, the number of outputs equals the number of complete groups times the active line length.
- R5: A sample carrying both `in_sol` and `in_sof` starts line number 0, whatever group position was reached before.
- R6: The active line length is 114 samples in three-line mode and 84 in four-line mode. Samples at column index ≥ that length (column 0 is the `in_sol` sample) are ignored and produce no output.
- R7: With `out_ready` held high, a kept result whose last input sample is accepted on rising edge e appears on `out_valid`/`out_data` right after edge e+DELAY−1. That is DELAY edges, counting the accepting one.
- R8: While `out_ready` is low, `out_valid` and `out_data` hold their values and no input is accepted. Every kept result is delivered exactly once, in order.
- R9: `in_sol` without `in_sof` advances the line number by one, wrapping after the last line of the group. A short line still counts as a full line position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 1 | 0: keep one of three lines, 1: keep one of four lines |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input accepted this cycle when high together with `in_valid` |
| in_data | input | 6 | Luma sample |
| in_sol | input | 1 | Sample is the first of a line |
| in_sof | input | 1 | Line is the first of a field (qualified by `in_sol`) |
| out_valid | output | 1 | Filtered sample offered |
| out_ready | input | 1 | Downstream takes the offered sample |
| out_data | output | 6 | Filtered luma sample |

## Verification
The bench builds the block with its default parameters: a 114-entry line limit, active lengths of 114 and 84, and a 4-slot alignment delay. The short delay makes it practical to measure the exact latency of a single kept result. Four-line fields with 100-sample lines exercise the column cut-off, and full-scale and zero luma fields reach the extremes of the sum and rounding. Random stalls and input gaps, combined with short lines and field starts in the middle of a group, exercise the freeze behaviour of the delay pipeline and the wrap of the group position.

// File: rtl/luma_vdecim_pkg.sv
package luma_vdecim_pkg;
  typedef enum logic {
    VD_THIRD   = 1'b0,
    VD_QUARTER = 1'b1
  } vd_mode_e;

  localparam int VD_PH_W = 2;
endpackage

// File: rtl/vd_group_track.sv
module vd_group_track
  import luma_vdecim_pkg::*;
#(
  parameter int LINE_MAX    = 114,
  parameter int LEN_THIRD   = 114,
  parameter int LEN_QUARTER = 84,
  parameter int COL_W       = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               sol,
  input  logic               sof,
  input  vd_mode_e           mode,
  output logic [COL_W-1:0]   cur_col,
  output logic               in_range,
  output logic               first_line,
  output logic               final_line,
  output logic               dbl_weight
);
  logic [VD_PH_W-1:0] phase_q, last_ph, next_ph, cur_phase;
  logic [COL_W-1:0]   col_q;

  always_comb begin
    last_ph = (mode == VD_QUARTER) ? VD_PH_W'(3) : VD_PH_W'(2);
    next_ph = (phase_q >= last_ph) ? '0 : phase_q + 1'b1;
    if (sol) cur_phase = sof ? '0 : next_ph;
    else     cur_phase = phase_q;
    if (sol)                              cur_col = '0;
    else if (col_q == COL_W'(LINE_MAX))   cur_col = col_q;
    else                                  cur_col = col_q + 1'b1;
    if (mode == VD_QUARTER) in_range = cur_col < COL_W'(LEN_QUARTER);
    else                    in_range = cur_col < COL_W'(LEN_THIRD);
    first_line = (cur_phase == '0);
    final_line = (cur_phase == last_ph);
    dbl_weight = (mode == VD_THIRD) && (cur_phase == VD_PH_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      col_q   <= '0;
    end else if (step) begin
      phase_q <= cur_phase;
      col_q   <= cur_col;
    end
  end
endmodule

// File: rtl/vd_line_accum.sv
module vd_line_accum #(
  parameter int LINE_MAX = 114,
  parameter int COL_W    = 7,
  parameter int Y_W      = 6,
  parameter int SUM_W    = Y_W + 2
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [COL_W-1:0] col,
  input  logic             first_line,
  input  logic             dbl_weight,
  input  logic [Y_W-1:0]   sample,
  output logic [SUM_W-1:0] sum
);
  logic [SUM_W-1:0] mem [LINE_MAX+1];
  logic [SUM_W-1:0] base, addend;

  always_comb begin
    base   = first_line ? '0 : mem[col];
    addend = dbl_weight ? {1'b0, sample, 1'b0} : {2'b00, sample};
    sum    = base + addend;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[col] <= sum;
  end
endmodule

// File: rtl/vd_delay_line.sv
module vd_delay_line #(
  parameter int DEPTH = 4,
  parameter int W     = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         in_vld,
  input  logic [W-1:0] in_dat,
  output logic         out_vld,
  output logic [W-1:0] out_dat
);
  generate
    if (DEPTH == 1) begin : g_single
      logic         v_q;
      logic [W-1:0] d_q;
      always_ff @(posedge clk) begin
        if (!rst_n)   v_q <= 1'b0;
        else if (adv) v_q <= in_vld;
      end
      always_ff @(posedge clk) begin
        if (adv) d_q <= in_dat;
      end
      assign out_vld = v_q;
      assign out_dat = d_q;
    end else begin : g_chain
      logic [DEPTH-1:0] v_q;
      logic [W-1:0]     d_q [DEPTH];
      always_ff @(posedge clk) begin
        if (!rst_n)   v_q <= '0;
        else if (adv) v_q <= {v_q[DEPTH-2:0], in_vld};
      end
      always_ff @(posedge clk) begin
        if (adv) begin
          d_q[0] <= in_dat;
          for (int i = 1; i < DEPTH; i++) d_q[i] <= d_q[i-1];
        end
      end
      assign out_vld = v_q[DEPTH-1];
      assign out_dat = d_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/luma_vdecim.sv
module luma_vdecim
  import luma_vdecim_pkg::*;
#(
  parameter int Y_W         = 6,
  parameter int LINE_MAX    = 114,
  parameter int LEN_THIRD   = 114,
  parameter int LEN_QUARTER = 84,
  parameter int DELAY       = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_sel,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [Y_W-1:0] in_data,
  input  logic           in_sol,
  input  logic           in_sof,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [Y_W-1:0] out_data
);
  localparam int COL_W = $clog2(LINE_MAX + 1);
  localparam int SUM_W = Y_W + 2;

  logic             take, in_range, first_line, final_line, dbl_weight;
  logic [COL_W-1:0] cur_col;
  logic [SUM_W-1:0] sum, rounded;
  logic             beat_vld;
  logic [Y_W-1:0]   beat_dat;

  assign in_ready = out_ready;
  assign take     = in_valid & out_ready;

  vd_group_track #(
    .LINE_MAX(LINE_MAX), .LEN_THIRD(LEN_THIRD),
    .LEN_QUARTER(LEN_QUARTER), .COL_W(COL_W)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .step(take), .sol(in_sol), .sof(in_sof),
    .mode(vd_mode_e'(mode_sel)), .cur_col(cur_col), .in_range(in_range),
    .first_line(first_line), .final_line(final_line), .dbl_weight(dbl_weight)
  );

  vd_line_accum #(
    .LINE_MAX(LINE_MAX), .COL_W(COL_W), .Y_W(Y_W), .SUM_W(SUM_W)
  ) u_accum (
    .clk(clk), .wr_en(take & in_range), .col(cur_col),
    .first_line(first_line), .dbl_weight(dbl_weight),
    .sample(in_data), .sum(sum)
  );

  always_comb begin
    rounded  = sum + SUM_W'(2);
    beat_dat = rounded[SUM_W-1:2];
    beat_vld = take & in_range & final_line;
  end

  vd_delay_line #(.DEPTH(DELAY), .W(Y_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .adv(out_ready),
    .in_vld(beat_vld), .in_dat(beat_dat),
    .out_vld(out_valid), .out_dat(out_data)
  );
endmodule

// File: rtl/luma_vdecim_chk.sv
module luma_vdecim_chk #(
  parameter int Y_W = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [Y_W-1:0] out_data
);
  int unsigned in_cnt, out_cnt;
  logic        seen_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cnt  <= 0;
      out_cnt <= 0;
      seen_in <= 1'b0;
    end else begin
      if (in_valid && in_ready)   in_cnt  <= in_cnt + 1;
      if (out_valid && out_ready) out_cnt <= out_cnt + 1;
      if (in_valid && in_ready)   seen_in <= 1'b1;
    end
  end

  // R8: offered result held while stalled
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: an empty slot stays empty while stalled
  p_idle_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !out_ready) |=> !out_valid);

  // R7: no result before any input was accepted
  p_out_needs_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> seen_in);

  // R4: decimation never emits more results than samples taken
  p_no_excess_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= in_cnt);
endmodule

bind luma_vdecim luma_vdecim_chk #(.Y_W(Y_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/luma_vdecim_tb_top.sv
module luma_vdecim_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DELAY  = 4;
  localparam int LMAX   = 114;
  localparam int LTHIRD = 114;
  localparam int LQUART = 84;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_sel = 1'b0, in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0, out_ready = 1'b1;
  logic [5:0] in_data = '0;
  logic in_ready, out_valid;
  logic [5:0] out_data;

  int n_tests = 0, n_fail = 0, cyc = 0, out_seen = 0;
  int last_acc = 0, first_acc = 0, first_out = -1;
  bit arm = 0, done_flag = 0;
  string tag = "R1";

  int m_ph = 0, m_col = 0;
  int m_sum [0:LMAX];
  int q[$];

  luma_vdecim dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_sol(in_sol), .in_sof(in_sof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int model_step();
    int last, cph, ccol, w, s, len;
    if (!in_valid) return -1;
    last = mode_sel ? 3 : 2;
    if (in_sol) cph = in_sof ? 0 : ((m_ph >= last) ? 0 : m_ph + 1);
    else        cph = m_ph;
    if (in_sol) ccol = 0;
    else        ccol = (m_col + 1 > LMAX) ? LMAX : m_col + 1;
    m_ph = cph; m_col = ccol;
    len = mode_sel ? LQUART : LTHIRD;
    if (ccol >= len) return -1;
    w = (!mode_sel && cph == 1) ? 2 : 1;
    s = ((cph == 0) ? 0 : m_sum[ccol]) + w * int'(in_data);
    m_sum[ccol] = s;
    if (cph != last) return -1;
    return (s + 2) / 4;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin : mon
    int ev;
    if (!rst_n) begin
      q.delete(); m_ph = 0; m_col = 0;
    end else begin
      ev = (q.size() >= DELAY) ? q[q.size()-DELAY] : -1;
      n_tests++;
      if (out_valid !== (ev >= 0) || (ev >= 0 && int'(out_data) != ev)) begin
        n_fail++;
        $display("FAIL %s stream: valid=%0b data=%0d expected valid=%0b data=%0d",
                 tag, out_valid, out_data, (ev >= 0), (ev >= 0) ? ev : 0);
      end
      if (arm && out_valid && first_out < 0) first_out = cyc;
      if (out_valid && out_ready) out_seen++;
      if (out_ready) begin
        q.push_back(model_step());
        if (q.size() > DELAY) void'(q.pop_front());
      end
    end
  end

  task automatic put(input logic [5:0] d, input logic sol, input logic sof,
                     input int stall_pct, input int gap_pct);
    bit r;
    while (gap_pct > 0 && $urandom_range(99) < gap_pct) begin
      in_valid = 1'b0;
      out_ready = ($urandom_range(99) >= stall_pct);
      @(posedge clk); #1;
    end
    in_valid = 1'b1; in_data = d; in_sol = sol; in_sof = sof;
    do begin
      r = (stall_pct == 0) || ($urandom_range(99) >= stall_pct);
      out_ready = r;
      @(posedge clk); #1;
      last_acc = cyc;
    end while (!r);
    in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0;
  endtask

  task automatic send_line(input logic m, input logic sof, input int len, input int kind,
                           input int seed, input int stall_pct, input int gap_pct);
    mode_sel = m;
    for (int c = 0; c < len; c++) begin
      logic [5:0] d;
      d = (kind == 1) ? 6'd63 : (kind == 2) ? 6'd0 : 6'((c * 7 + seed * 13 + c * c) % 64);
      put(d, (c == 0), (c == 0) && sof, stall_pct, gap_pct);
      if (c == 0) first_acc = last_acc;
    end
  endtask

  task automatic drain();
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (DELAY + 3) @(posedge clk);
    #1;
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    int s0;
    // R1: reset state
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 out_valid in reset", out_valid, 0);
    check("R1 ready follows", in_ready, 1);
    out_ready = 1'b0; #1;
    check("R1 ready follows low", in_ready, 0);
    out_ready = 1'b1;
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 out_valid after reset", out_valid, 0);

    // R2: three-line mode, two full groups plus a partial one
    tag = "R2"; s0 = out_seen;
    for (int l = 0; l < 7; l++) send_line(1'b0, l == 0, 114, 0, l, 0, 0);
    drain();
    check("R2 output count", out_seen - s0, 228);
    // R2 extremes: full scale and zero
    s0 = out_seen;
    for (int l = 0; l < 3; l++) send_line(1'b0, l == 0, 114, 1, 0, 0, 0);
    for (int l = 0; l < 3; l++) send_line(1'b0, l == 0, 114, 2, 0, 0, 0);
    drain();
    check("R2 extreme count", out_seen - s0, 228);

    // R3: four-line mode
    tag = "R3"; s0 = out_seen;
    for (int l = 0; l < 9; l++) send_line(1'b1, l == 0, 84, 0, l + 3, 0, 0);
    drain();
    check("R3 R4 output count", out_seen - s0, 168);

    // R5: field start in the middle of a group
    tag = "R5"; s0 = out_seen;
    send_line(1'b0, 1'b1, 114, 0, 20, 0, 0);
    send_line(1'b0, 1'b0, 114, 0, 21, 0, 0);
    for (int l = 0; l < 3; l++) send_line(1'b0, l == 0, 114, 0, 22 + l, 0, 0);
    drain();
    check("R5 restart count", out_seen - s0, 114);

    // R6: overlong lines in four-line mode
    tag = "R6"; s0 = out_seen;
    for (int l = 0; l < 4; l++) send_line(1'b1, l == 0, 100, 0, 30 + l, 0, 0);
    drain();
    check("R6 clipped count", out_seen - s0, 84);

    // R9: short line still takes a group position
    tag = "R9"; s0 = out_seen;
    send_line(1'b0, 1'b1, 114, 0, 40, 0, 0);
    send_line(1'b0, 1'b0, 60, 0, 41, 0, 0);
    send_line(1'b0, 1'b0, 114, 0, 42, 0, 0);
    send_line(1'b0, 1'b0, 114, 0, 43, 0, 0);
    drain();
    check("R9 wrap count", out_seen - s0, 114);

    // R8: random back-pressure and input gaps
    tag = "R8"; s0 = out_seen;
    for (int l = 0; l < 6; l++) send_line(1'b0, l == 0, 114, 0, 50 + l, 40, 30);
    for (int l = 0; l < 4; l++) send_line(1'b1, l == 0, 84, 0, 60 + l, 50, 20);
    drain();
    check("R8 delivered once", out_seen - s0, 228 + 84);

    // R7: latency of the first kept result
    tag = "R7";
    for (int l = 0; l < 3; l++) send_line(1'b1, l == 0, 84, 0, 70 + l, 0, 0);
    drain();
    arm = 1; first_out = -1;
    send_line(1'b1, 1'b0, 84, 0, 73, 0, 0);
    drain();
    check("R7 latency edges", first_out - first_acc, DELAY - 1);

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule